// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers a single best candidate: an ID, an 8-bit priority value and a valid flag. The block decides whether that candidate may interrupt the processor and raises `irq_o` when it may. Three conditions must hold. Signalling must be enabled. The candidate's priority value must be numerically below a programmable threshold. The value must also be strictly below the running priority of the interrupt currently being serviced. A lower value means a more urgent interrupt.

Software works through a small register window. Reading the acknowledge register returns the candidate's ID and makes that interrupt active. The block pushes the ID and priority onto a nesting stack of parameterised depth (4 by default) and pulses `ack_o` so that the distributor can clear its pending state. If nothing qualifies, the read returns the spurious ID 1023 and changes no state. Writing an ID to the end-of-interrupt register retires the most recently acknowledged interrupt. The running priority then falls back to the entry below it, or to idle when the stack is empty.

A three-state machine drives the request line. OFF means signalling is disabled. IDLE means signalling is enabled but no candidate qualifies. ASSERT means a candidate qualifies and `irq_o` is high. From every state, the next state is chosen by the same rules: disabled leads to OFF (the disable transition); enabled with a qualifying candidate leads to ASSERT (the raise transition); enabled without one leads to IDLE (the drop transition).

Top module: `cpu_ack_if`

## Requirements
- R1: After reset `irq_o` is low, the control enable reads 0, the priority mask reads 0x00 and no interrupt is active.
- R2: While control bit 0 (register select 0) is clear, `irq_o` stays low and an acknowledge read returns 1023.
- R3: A candidate is signalled only when it is valid and its priority value is strictly below the mask (register select 1, bits [7:0]). An equal value is blocked.
- R4: `irq_o` follows a change in qualification exactly one clock cycle later.
- R5: A read of register select 2 returns the candidate ID in bits [9:0], with all higher bits zero, one cycle after the read. In that same cycle the block pulses `ack_o` with `ack_id_o` equal to that ID, and the interrupt becomes active.
- R6: When no candidate qualifies, an acknowledge read returns 1023, does not pulse `ack_o` and changes no state.
- R7: While an interrupt is active, only a candidate whose priority value is strictly below the active one is signalled. A candidate at equal or higher value is held off.
- R8: At most DEPTH interrupts are active at once. With the stack full, no candidate qualifies.
- R9: A write to register select 3 whose bits [9:0] equal the most recently acknowledged active ID retires that interrupt. It pulses `eoi_o` with `eoi_id_o` one cycle later and restores the previous running priority.
- R10: An end-of-interrupt write whose ID is not the most recently acknowledged active one, or that arrives when nothing is active, is ignored: no `eoi_o` pulse and no change in running priority.
- R11: Registers 0 and 1 read back the stored enable bit and mask, one cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cand_valid_i | input | 1 | Distributor offers a candidate |
| cand_id_i | input | ID_W | Candidate interrupt ID |
| cand_prio_i | input | PRIO_W | Candidate priority value (lower is more urgent) |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 control, 1 mask, 2 acknowledge, 3 end-of-interrupt |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after the read |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_o | output | 1 | One-cycle pulse: candidate acknowledged |
| ack_id_o | output | ID_W | ID acknowledged |
| eoi_o | output | 1 | One-cycle pulse: active interrupt retired |
| eoi_id_o | output | ID_W | ID retired |

## Verification
Read data, the `ack_o` pulse and the `eoi_o` pulse are registered. They appear in the cycle after the strobe, so the bench captures them just after the edge that takes the strobe. `irq_o` lags qualification by one register stage. The bench checks that it is still low immediately after the candidate changes and high after the next edge. After every register write or acknowledge, the bench waits two edges before sampling `irq_o`: one for the register or stack update and one for the state machine.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_PMASK = 2'd1,
        REG_ACK   = 2'd2,
        REG_EOI   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_ASSERT = 2'd2
    } irq_state_e;

    localparam int unsigned SPURIOUS_ID = 1023;

endpackage

// File: rtl/cpuif_prio_stack.sv
module cpuif_prio_stack #(
    parameter int DEPTH  = 4,
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [ID_W-1:0]   id_i,
    input  logic [PRIO_W-1:0] prio_i,
    output logic [ID_W-1:0]   top_id_o,
    output logic [PRIO_W-1:0] top_prio_o,
    output logic              empty_o,
    output logic              full_o,
    output logic [CNT_W-1:0]  count_o
);

    logic [CNT_W-1:0]  count_q;
    logic [ID_W-1:0]   ent_id   [DEPTH];
    logic [PRIO_W-1:0] ent_prio [DEPTH];
    logic              do_pop;
    logic              do_push;
    logic [CNT_W-1:0]  wr_idx;

    assign empty_o = (count_q == '0);
    assign full_o  = (count_q == CNT_W'(DEPTH));
    assign count_o = count_q;
    assign do_pop  = pop_i && !empty_o;
    assign do_push = push_i && (!full_o || do_pop);
    // A simultaneous retire and acknowledge replaces the top entry.
    assign wr_idx  = do_pop ? count_q - 1'b1 : count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent_id[i]   <= '0;
                ent_prio[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (do_push && wr_idx == CNT_W'(i)) begin
                    ent_id[i]   <= id_i;
                    ent_prio[i] <= prio_i;
                end
            end
            count_q <= count_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_comb begin
        top_id_o   = '0;
        top_prio_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (count_q == CNT_W'(i + 1)) begin
                top_id_o   = ent_id[i];
                top_prio_o = ent_prio[i];
            end
        end
    end

endmodule

// File: rtl/cpuif_irq_fsm.sv
module cpuif_irq_fsm
    import cpuif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic qualify_i,
    output logic irq_o
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_OFF: begin
                if (!enable_i)      state_d = ST_OFF;
                else if (qualify_i) state_d = ST_ASSERT;
                else                state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (!enable_i)      state_d = ST_OFF;
                else if (qualify_i) state_d = ST_ASSERT;
                else                state_d = ST_IDLE;
            end
            ST_ASSERT: begin
                if (!enable_i)      state_d = ST_OFF;
                else if (qualify_i) state_d = ST_ASSERT;
                else                state_d = ST_IDLE;
            end
            default:                state_d = ST_OFF;
        endcase
    end

    always_comb begin
        irq_o = (state_q == ST_ASSERT);
    end

endmodule

// File: rtl/cpu_ack_if.sv
module cpu_ack_if
    import cpuif_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_valid_i,
    input  logic [ID_W-1:0]   cand_id_i,
    input  logic [PRIO_W-1:0] cand_prio_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              ack_o,
    output logic [ID_W-1:0]   ack_id_o,
    output logic              eoi_o,
    output logic [ID_W-1:0]   eoi_id_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              ctrl_en_q;
    logic [PRIO_W-1:0] pmask_q;
    logic [ID_W-1:0]   top_id;
    logic [PRIO_W-1:0] top_prio;
    logic              stk_empty;
    logic              stk_full;
    logic [CNT_W-1:0]  stk_count;
    logic [PRIO_W:0]   running;
    logic              qualify;
    logic              ack_rd;
    logic              eoi_wr;
    logic              push;
    logic              pop;

    // Idle running priority sits above every representable value.
    assign running = stk_empty ? {1'b1, {PRIO_W{1'b0}}} : {1'b0, top_prio};
    assign qualify = ctrl_en_q && cand_valid_i && !stk_full
                   && (cand_prio_i < pmask_q)
                   && ({1'b0, cand_prio_i} < running);
    assign ack_rd  = rd_en_i && (addr_i == REG_ACK);
    assign eoi_wr  = wr_en_i && (addr_i == REG_EOI);
    assign push    = ack_rd && qualify;
    assign pop     = eoi_wr && !stk_empty && (wdata_i[ID_W-1:0] == top_id);

    cpuif_prio_stack #(
        .DEPTH (DEPTH),
        .ID_W  (ID_W),
        .PRIO_W(PRIO_W),
        .CNT_W (CNT_W)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push),
        .pop_i     (pop),
        .id_i      (cand_id_i),
        .prio_i    (cand_prio_i),
        .top_id_o  (top_id),
        .top_prio_o(top_prio),
        .empty_o   (stk_empty),
        .full_o    (stk_full),
        .count_o   (stk_count)
    );

    cpuif_irq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (ctrl_en_q),
        .qualify_i(qualify),
        .irq_o    (irq_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en_q <= 1'b0;
            pmask_q   <= '0;
        end else if (wr_en_i) begin
            if (addr_i == REG_CTRL)  ctrl_en_q <= wdata_i[0];
            if (addr_i == REG_PMASK) pmask_q   <= wdata_i[PRIO_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o  <= '0;
            ack_o    <= 1'b0;
            ack_id_o <= '0;
            eoi_o    <= 1'b0;
            eoi_id_o <= '0;
        end else begin
            ack_o <= push;
            eoi_o <= pop;
            if (push) ack_id_o <= cand_id_i;
            if (pop)  eoi_id_o <= top_id;
            if (rd_en_i) begin
                unique case (addr_i)
                    REG_CTRL:  rdata_o <= DATA_W'(ctrl_en_q);
                    REG_PMASK: rdata_o <= DATA_W'(pmask_q);
                    REG_ACK:   rdata_o <= qualify ? DATA_W'(cand_id_i)
                                                  : DATA_W'(SPURIOUS_ID);
                    REG_EOI:   rdata_o <= '0;
                    default:   rdata_o <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/cpu_ack_if_chk.sv
module cpu_ack_if_chk #(
    parameter int DEPTH  = 4,
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cand_valid_i,
    input logic [ID_W-1:0]   cand_id_i,
    input logic [PRIO_W-1:0] cand_prio_i,
    input logic              rd_en_i,
    input logic              wr_en_i,
    input logic [1:0]        addr_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              irq_o,
    input logic              ack_o,
    input logic [ID_W-1:0]   ack_id_o,
    input logic              eoi_o,
    input logic              ctrl_en_q,
    input logic [PRIO_W-1:0] pmask_q,
    input logic [CNT_W-1:0]  stk_count
);

    // R2: a cleared enable forces the request low on the next cycle
    p_irq_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en_q |=> !irq_o);

    // R3: a raised request implies a valid candidate under the mask one cycle earlier
    p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(cand_valid_i && (cand_prio_i < pmask_q)));

    // R5: the acknowledge pulse carries the ID that was offered and the read data matches
    p_ack_id_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (ack_id_o == $past(cand_id_i)) && (rdata_o[ID_W-1:0] == ack_id_o));

    // R5: an acknowledge pulse only follows an acknowledge read
    p_ack_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(rd_en_i && addr_i == 2'd2));

    // R6: with no candidate offered, the acknowledge read is spurious
    p_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == 2'd2 && !cand_valid_i) |=>
            (rdata_o[ID_W-1:0] == {ID_W{1'b1}}) && !ack_o);

    // R8: the number of active interrupts never exceeds the stack depth
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stk_count <= CNT_W'(DEPTH));

    // R10: a retire pulse only follows an end-of-interrupt write
    p_eoi_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_o |-> $past(wr_en_i && addr_i == 2'd3));

endmodule

bind cpu_ack_if cpu_ack_if_chk #(
    .DEPTH (DEPTH),
    .ID_W  (ID_W),
    .PRIO_W(PRIO_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cand_valid_i(cand_valid_i),
    .cand_id_i   (cand_id_i),
    .cand_prio_i (cand_prio_i),
    .rd_en_i     (rd_en_i),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .rdata_o     (rdata_o),
    .irq_o       (irq_o),
    .ack_o       (ack_o),
    .ack_id_o    (ack_id_o),
    .eoi_o       (eoi_o),
    .ctrl_en_q   (ctrl_en_q),
    .pmask_q     (pmask_q),
    .stk_count   (stk_count)
);

// File: tb/tb_cpu_ack_if.sv
module tb_cpu_ack_if;

    localparam int CLK_PERIOD = 10;
    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;
    localparam int DATA_W = 32;

    // {enable, mask[7:0], prio[7:0], valid, expected irq}
    localparam int NVEC = 8;
    localparam logic [18:0] VEC [NVEC] = '{
        {1'b1, 8'hF0, 8'h80, 1'b1, 1'b1},
        {1'b1, 8'hF0, 8'hF0, 1'b1, 1'b0},
        {1'b1, 8'hF0, 8'hEF, 1'b1, 1'b1},
        {1'b0, 8'hF0, 8'h10, 1'b1, 1'b0},
        {1'b1, 8'h00, 8'h00, 1'b1, 1'b0},
        {1'b1, 8'hFF, 8'hFE, 1'b1, 1'b1},
        {1'b1, 8'hFF, 8'h00, 1'b0, 1'b0},
        {1'b1, 8'h01, 8'h00, 1'b1, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cand_valid_i = 1'b0;
    logic [ID_W-1:0]   cand_id_i = '0;
    logic [PRIO_W-1:0] cand_prio_i = '0;
    logic              rd_en_i = 1'b0;
    logic              wr_en_i = 1'b0;
    logic [1:0]        addr_i = '0;
    logic [DATA_W-1:0] wdata_i = '0;
    logic [DATA_W-1:0] rdata_o;
    logic              irq_o;
    logic              ack_o;
    logic [ID_W-1:0]   ack_id_o;
    logic              eoi_o;
    logic [ID_W-1:0]   eoi_id_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [DATA_W-1:0] rd_val;
    logic              rd_ack;
    logic [ID_W-1:0]   rd_ack_id;
    logic              wr_eoi;
    logic [ID_W-1:0]   wr_eoi_id;

    cpu_ack_if dut (
        .clk(clk), .rst_n(rst_n),
        .cand_valid_i(cand_valid_i), .cand_id_i(cand_id_i), .cand_prio_i(cand_prio_i),
        .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_o(irq_o), .ack_o(ack_o), .ack_id_o(ack_id_o),
        .eoi_o(eoi_o), .eoi_id_o(eoi_id_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(posedge clk); #1;
        wr_eoi = eoi_o; wr_eoi_id = eoi_id_o;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        @(negedge clk);
        rd_en_i = 1'b1; addr_i = a;
        @(posedge clk); #1;
        rd_val = rdata_o; rd_ack = ack_o; rd_ack_id = ack_id_o;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk); @(negedge clk);
    endtask

    task automatic offer(input logic v, input logic [9:0] id, input logic [7:0] p);
        @(negedge clk);
        cand_valid_i = v; cand_id_i = id; cand_prio_i = p;
        settle();
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq after reset", 32'(irq_o), 32'd0);
        rd(2'd0); check("R1 enable after reset", rd_val, 32'd0);
        rd(2'd1); check("R1 mask after reset", rd_val, 32'd0);
        // R6: nothing offered gives spurious
        rd(2'd2);
        check("R6 spurious id", rd_val, 32'd1023);
        check("R6 no ack pulse", 32'(rd_ack), 32'd0);

        // R3 / R2: table of patterns
        for (int i = 0; i < NVEC; i++) begin
            wr(2'd0, 32'(VEC[i][18]));
            wr(2'd1, 32'(VEC[i][17:10]));
            offer(VEC[i][1], 10'd7, VEC[i][9:2]);
            check($sformatf("R3 vector %0d irq", i), 32'(irq_o), 32'(VEC[i][0]));
        end

        // R11: register readback
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'h0000_12F0);
        rd(2'd0); check("R11 enable readback", rd_val, 32'd1);
        rd(2'd1); check("R11 mask readback", rd_val, 32'h0000_00F0);

        // R4: one-cycle latency from qualification to irq
        offer(1'b0, 10'd0, 8'h00);
        @(negedge clk);
        cand_valid_i = 1'b1; cand_id_i = 10'd40; cand_prio_i = 8'h80;
        #1 check("R4 irq not yet", 32'(irq_o), 32'd0);
        @(negedge clk);
        check("R4 irq after one edge", 32'(irq_o), 32'd1);

        // R5: acknowledge
        rd(2'd2);
        check("R5 ack read id", rd_val, 32'd40);
        check("R5 ack pulse", 32'(rd_ack), 32'd1);
        check("R5 ack id", 32'(rd_ack_id), 32'd40);
        settle();
        // R7: equal priority blocked while active
        check("R7 equal prio held off", 32'(irq_o), 32'd0);
        rd(2'd2);
        check("R7 equal prio ack spurious", rd_val, 32'd1023);
        check("R6 spurious no pulse", 32'(rd_ack), 32'd0);
        offer(1'b1, 10'd45, 8'h90);
        check("R7 lower urgency held off", 32'(irq_o), 32'd0);

        // R8: nest to depth 4
        offer(1'b1, 10'd41, 8'h60);
        check("R7 preempt irq", 32'(irq_o), 32'd1);
        rd(2'd2); check("R5 nested ack 41", rd_val, 32'd41);
        offer(1'b1, 10'd42, 8'h40);
        rd(2'd2); check("R5 nested ack 42", rd_val, 32'd42);
        offer(1'b1, 10'd43, 8'h20);
        rd(2'd2); check("R5 nested ack 43", rd_val, 32'd43);
        offer(1'b1, 10'd44, 8'h10);
        check("R8 full stack no irq", 32'(irq_o), 32'd0);
        rd(2'd2); check("R8 full stack spurious", rd_val, 32'd1023);

        // R10: mismatched retire ignored
        wr(2'd3, 32'd42);
        check("R10 wrong id no eoi", 32'(wr_eoi), 32'd0);
        wr(2'd3, 32'd99);
        check("R10 unknown id no eoi", 32'(wr_eoi), 32'd0);
        settle();
        check("R10 still full", 32'(irq_o), 32'd0);

        // R9: matching retire
        wr(2'd3, 32'd43);
        check("R9 eoi pulse", 32'(wr_eoi), 32'd1);
        check("R9 eoi id", 32'(wr_eoi_id), 32'd43);
        settle();
        check("R9 prio restored irq", 32'(irq_o), 32'd1);
        offer(1'b1, 10'd44, 8'h40);
        check("R9 running now 0x40 blocks equal", 32'(irq_o), 32'd0);
        wr(2'd3, 32'd42); check("R9 eoi 42", 32'(wr_eoi_id), 32'd42);
        wr(2'd3, 32'd41); check("R9 eoi 41", 32'(wr_eoi_id), 32'd41);
        wr(2'd3, 32'd40); check("R9 eoi 40", 32'(wr_eoi), 32'd1);
        offer(1'b1, 10'd50, 8'hE0);
        check("R9 idle running irq", 32'(irq_o), 32'd1);
        offer(1'b1, 10'd50, 8'hF0);
        check("R3 mask boundary", 32'(irq_o), 32'd0);

        // R10: retire with nothing active
        wr(2'd3, 32'd40);
        check("R10 empty no eoi", 32'(wr_eoi), 32'd0);

        // R2: disable blocks irq and acknowledge
        offer(1'b1, 10'd51, 8'h10);
        check("R2 enabled irq", 32'(irq_o), 32'd1);
        wr(2'd0, 32'd0);
        settle();
        check("R2 disabled irq", 32'(irq_o), 32'd0);
        rd(2'd2);
        check("R2 disabled ack spurious", rd_val, 32'd1023);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule